// File: doc/BRIEF.md
# Abstract Register Access Engine

This block carries out register-access commands that an external debugger posts while the hart is stopped. A posted 32-bit command word is split into a command type, a transfer size, post-increment and post-execute flags, a transfer flag, a write flag and a 16-bit register number. In the cycle the command is posted, the engine raises one read or write strobe toward the hart's integer register file, floating-point register file or CSR port. Read results are captured into two 32-bit data registers on the next clock edge.

Every access finishes in the cycle it is issued, so the busy indication is never raised. A response strobe follows every posted command one cycle later, and that includes commands that fail or are ignored. Failures are recorded in a 3-bit error field. The field stays set until the debugger writes ones to the bits it wants cleared. While the field is nonzero, new commands do nothing.

Top module: `abs_access_engine`

## Requirements
- R1: `resp_valid` is high in exactly the cycle after each cycle with `cmd_wr` high, whatever the command's outcome, and low otherwise; after reset `data0`, `data1`, `cmderr` and `resp_valid` are 0.
- R2: A read of an integer register (register number 0x1000+i, i in 0..31, write flag bit 16 = 0, transfer bit 17 = 1, size bits 22:20) strobes `gpr_rd` with `rf_idx`=i in the command cycle. On the next edge, the low 32 bits go to `data0`. With size 3, the high 32 bits go to `data1`; with size 2, `data1` is left unchanged.
- R3: A write of an integer register strobes `gpr_wr` with `wr_data` = {`data1`,`data0`} for size 3, or `data0` zero-extended for size 2, in the command cycle.
- R4: Register numbers 0x0000–0x0FFF reach the CSR port as `csr_rd` or `csr_wr` with `csr_idx` = the low 12 bits, with the same data placement as R2/R3.
- R5: Register numbers 0x1020–0x103F read the floating-point register (index = low 5 bits) through `fpr_rd`. A write to that range sets error 2 and raises no strobe.
- R6: Register numbers 0x07A0–0x07AF (trigger registers) set error 3 and raise no strobe.
- R7: A command posted while `hart_halted` is 0 sets error 4 and raises no strobe.
- R8: Error 2 is set with no strobe when the command type (bits 31:24) is nonzero, when post-increment (bit 19) or post-execute (bit 18) is set, when a transfer has a size other than 2, or 3 on a 64-bit hart, or when the register number lies outside the three ranges.
- R9: While `cmderr` is nonzero, a posted command raises no strobe and changes neither the data registers nor `cmderr`. A write with `err_clr_wr` clears exactly the bits set in `err_clr_mask`.
- R10: A command with the transfer flag at 0 and no other error raises no strobe and leaves `cmderr` at 0.
- R11: `busy` is always 0. `datacount` is 2 for a 64-bit hart and 1 for a 32-bit hart.
- R12: `data0_wr`/`data1_wr` load the data registers on the next edge. A command read that captures into the same register in that cycle takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hart_halted | input | 1 | Hart is stopped in debug state |
| cmd_wr | input | 1 | Command word posted this cycle |
| cmd_word | input | 32 | Command word |
| data0_wr | input | 1 | Debugger write to data register 0 |
| data0_wdata | input | 32 | Value for data register 0 |
| data1_wr | input | 1 | Debugger write to data register 1 |
| data1_wdata | input | 32 | Value for data register 1 |
| err_clr_wr | input | 1 | Write-ones-to-clear on the error field |
| err_clr_mask | input | 3 | Error bits to clear |
| gpr_rdata | input | XLEN | Integer register read data (combinational) |
| fpr_rdata | input | XLEN | Floating-point register read data (combinational) |
| csr_rdata | input | XLEN | CSR read data (combinational) |
| rf_idx | output | 5 | Integer/floating-point register index |
| csr_idx | output | 12 | CSR address |
| gpr_rd | output | 1 | Integer register read strobe |
| gpr_wr | output | 1 | Integer register write strobe |
| fpr_rd | output | 1 | Floating-point register read strobe |
| csr_rd | output | 1 | CSR read strobe |
| csr_wr | output | 1 | CSR write strobe |
| wr_data | output | XLEN | Write data toward the hart |
| data0 | output | 32 | Data register 0 |
| data1 | output | 32 | Data register 1 |
| cmderr | output | 3 | Sticky command error code |
| busy | output | 1 | Command in progress (always 0) |
| datacount | output | 4 | Number of data registers |
| resp_valid | output | 1 | Response strobe, one per command |

## Verification
The assertions assume that the register file read data is valid combinationally in the cycle its strobe is raised, and that the hart obeys the strobes in that same cycle. They also assume `cmd_wr` is a single-cycle pulse per command. The bench keeps within these assumptions by backing all three register ports with arrays indexed directly from the engine's index outputs. It drives every input on the falling edge and holds each command high for one cycle only. It never posts a debugger data write in the same cycle as a command, except where the precedence rule itself is under test.

// File: rtl/absacc_pkg.sv
// Shared encodings for the abstract register access engine.
// Assumes the standard command word layout that a debugger produces.
package absacc_pkg;

    // Error codes reported in the sticky error field
    typedef enum logic [2:0] {
        ERR_NONE   = 3'd0,
        ERR_UNSUP  = 3'd2,
        ERR_EXCEPT = 3'd3,
        ERR_STATE  = 3'd4
    } err_code_t;

    // Which hart port a command targets
    typedef enum logic [1:0] {
        ACC_NONE,
        ACC_GPR,
        ACC_FPR,
        ACC_CSR
    } acc_kind_t;

    // Command word fields, MSB first; positions are fixed by the debugger
    typedef struct packed {
        logic [7:0]  cmd_type;
        logic        rsvd;
        logic [2:0]  size;
        logic        post_inc;
        logic        post_exec;
        logic        transfer;
        logic        write;
        logic [15:0] regno;
    } cmd_fields_t;

    localparam logic [7:0]  CMD_TYPE_REG  = 8'd0;
    localparam logic [10:0] GPR_BASE_HI   = 11'h080;  // regno[15:5] for 0x1000..0x101F
    localparam logic [10:0] FPR_BASE_HI   = 11'h081;  // regno[15:5] for 0x1020..0x103F
    localparam logic [7:0]  TRIG_BLOCK_HI = 8'h7A;    // regno[11:4] for 0x7A0..0x7AF
    localparam logic [2:0]  SIZE_32       = 3'd2;
    localparam logic [2:0]  SIZE_64       = 3'd3;

endpackage

// File: rtl/absacc_decode.sv
// Combinational command decoder.
// Classifies a posted command into one hart access or one error code.
// Assumes cmd_wr is a one-cycle pulse; a pending error blocks decoding.
module absacc_decode
    import absacc_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_wr,
    input  logic [31:0] cmd_word,
    input  logic        hart_halted,
    input  logic        err_pending,
    output acc_kind_t   acc_kind,
    output logic        acc_write,
    output logic        acc_wide,
    output logic        err_set,
    output err_code_t   err_code
);
    localparam logic [2:0] MAX_SIZE = (XLEN == 64) ? SIZE_64 : SIZE_32;

    cmd_fields_t fld;
    logic        size_ok;
    logic        in_csr;
    logic        in_trig;
    logic        in_gpr;
    logic        in_fpr;

    assign fld     = cmd_fields_t'(cmd_word);
    assign size_ok = (fld.size >= SIZE_32) && (fld.size <= MAX_SIZE);
    assign in_csr  = (fld.regno[15:12] == 4'h0);
    assign in_trig = in_csr && (fld.regno[11:4] == TRIG_BLOCK_HI);
    assign in_gpr  = (fld.regno[15:5] == GPR_BASE_HI);
    assign in_fpr  = (fld.regno[15:5] == FPR_BASE_HI);

    // Priority classification: state, command form, size, register range
    always_comb begin
        acc_kind  = ACC_NONE;
        acc_write = fld.write;
        acc_wide  = (fld.size == SIZE_64);
        err_set   = 1'b0;
        err_code  = ERR_NONE;
        if (cmd_wr && !err_pending) begin
            if (!hart_halted) begin
                err_set  = 1'b1;
                err_code = ERR_STATE;
            end else if (fld.cmd_type != CMD_TYPE_REG || fld.post_inc || fld.post_exec) begin
                err_set  = 1'b1;
                err_code = ERR_UNSUP;
            end else if (fld.transfer) begin
                if (!size_ok) begin
                    err_set  = 1'b1;
                    err_code = ERR_UNSUP;
                end else if (in_trig) begin
                    err_set  = 1'b1;
                    err_code = ERR_EXCEPT;
                end else if (in_csr) begin
                    acc_kind = ACC_CSR;
                end else if (in_gpr) begin
                    acc_kind = ACC_GPR;
                end else if (in_fpr && !fld.write) begin
                    acc_kind = ACC_FPR;
                end else begin
                    err_set  = 1'b1;
                    err_code = ERR_UNSUP;
                end
            end
        end
    end

    // R8: an errored command never also selects a hart port
    err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_set |-> (acc_kind == ACC_NONE));

    // R9: nothing is decoded while an earlier error is pending
    blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_pending |-> (!err_set && acc_kind == ACC_NONE));

endmodule

// File: rtl/absacc_data.sv
// Two 32-bit data registers shared between the debugger and the engine.
// A command read capture takes precedence over a debugger write the same cycle.
// For a 32-bit hart the second register does not exist and reads 0.
module absacc_data #(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            d0_wr,
    input  logic [31:0]     d0_wdata,
    input  logic            d1_wr,
    input  logic [31:0]     d1_wdata,
    input  logic            cap_en,
    input  logic            cap_wide,
    input  logic [XLEN-1:0] cap_val,
    output logic [31:0]     data0,
    output logic [31:0]     data1
);
    // Low data register: capture first, then debugger write
    always_ff @(posedge clk) begin
        if (!rst_n)
            data0 <= '0;
        else if (cap_en)
            data0 <= cap_val[31:0];
        else if (d0_wr)
            data0 <= d0_wdata;
    end

    generate
        if (XLEN == 64) begin : g_wide
            // High data register: filled only by 64-bit captures
            always_ff @(posedge clk) begin
                if (!rst_n)
                    data1 <= '0;
                else if (cap_en && cap_wide)
                    data1 <= cap_val[63:32];
                else if (d1_wr)
                    data1 <= d1_wdata;
            end
        end else begin : g_narrow
            assign data1 = '0;
        end
    endgenerate

    // R12: a debugger write with no capture lands one cycle later
    d0_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (d0_wr && !cap_en) |=> (data0 == $past(d0_wdata)));

    // R2: a narrow capture leaves the high register alone
    d1_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_en && !cap_wide && !d1_wr) |=> $stable(data1));

endmodule

// File: rtl/absacc_err.sv
// Sticky command error field with write-ones-to-clear.
// Assumes the decoder raises set_en only while the field is clear.
module absacc_err (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set_en,
    input  logic [2:0] set_code,
    input  logic       clr_wr,
    input  logic [2:0] clr_mask,
    output logic [2:0] cmderr
);
    // Record a new error, otherwise apply a clear request
    always_ff @(posedge clk) begin
        if (!rst_n)
            cmderr <= 3'd0;
        else if (set_en)
            cmderr <= set_code;
        else if (clr_wr)
            cmderr <= cmderr & ~clr_mask;
    end

    // R9: a pending error holds until a clear is written
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmderr != 3'd0) && !clr_wr) |=> (cmderr == $past(cmderr)));

    // R9: a clear never sets bits
    err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && !set_en) |=> ((cmderr & ~$past(cmderr)) == 3'd0));

endmodule

// File: rtl/abs_access_engine.sv
// Abstract register access engine: executes register-access commands
// against the halted hart in the cycle they are posted.
// Assumes the hart's read data is valid combinationally with each strobe.
module abs_access_engine
    import absacc_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hart_halted,
    input  logic            cmd_wr,
    input  logic [31:0]     cmd_word,
    input  logic            data0_wr,
    input  logic [31:0]     data0_wdata,
    input  logic            data1_wr,
    input  logic [31:0]     data1_wdata,
    input  logic            err_clr_wr,
    input  logic [2:0]      err_clr_mask,
    input  logic [XLEN-1:0] gpr_rdata,
    input  logic [XLEN-1:0] fpr_rdata,
    input  logic [XLEN-1:0] csr_rdata,
    output logic [4:0]      rf_idx,
    output logic [11:0]     csr_idx,
    output logic            gpr_rd,
    output logic            gpr_wr,
    output logic            fpr_rd,
    output logic            csr_rd,
    output logic            csr_wr,
    output logic [XLEN-1:0] wr_data,
    output logic [31:0]     data0,
    output logic [31:0]     data1,
    output logic [2:0]      cmderr,
    output logic            busy,
    output logic [3:0]      datacount,
    output logic            resp_valid
);
    localparam int DATA_REGS = XLEN / 32;

    acc_kind_t       acc_kind;
    logic            acc_write;
    logic            acc_wide;
    logic            err_set;
    err_code_t       err_code;
    logic            cap_en;
    logic [XLEN-1:0] rd_val;
    logic            resp_q;

    absacc_decode #(.XLEN(XLEN)) u_decode (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_wr      (cmd_wr),
        .cmd_word    (cmd_word),
        .hart_halted (hart_halted),
        .err_pending (cmderr != 3'd0),
        .acc_kind    (acc_kind),
        .acc_write   (acc_write),
        .acc_wide    (acc_wide),
        .err_set     (err_set),
        .err_code    (err_code)
    );

    // Strobes toward the hart, one per accepted command
    assign gpr_rd  = (acc_kind == ACC_GPR) && !acc_write;
    assign gpr_wr  = (acc_kind == ACC_GPR) &&  acc_write;
    assign fpr_rd  = (acc_kind == ACC_FPR);
    assign csr_rd  = (acc_kind == ACC_CSR) && !acc_write;
    assign csr_wr  = (acc_kind == ACC_CSR) &&  acc_write;
    assign rf_idx  = cmd_word[4:0];
    assign csr_idx = cmd_word[11:0];

    // Select the read data of whichever port was strobed
    always_comb begin
        unique case (acc_kind)
            ACC_GPR: rd_val = gpr_rdata;
            ACC_FPR: rd_val = fpr_rdata;
            ACC_CSR: rd_val = csr_rdata;
            default: rd_val = '0;
        endcase
    end
    assign cap_en = gpr_rd || fpr_rd || csr_rd;

    // Outgoing write value: width chosen by the hart size
    generate
        if (XLEN == 64) begin : g_wd64
            assign wr_data = acc_wide ? {data1, data0} : {32'd0, data0};
        end else begin : g_wd32
            assign wr_data = data0;
        end
    endgenerate

    absacc_data #(.XLEN(XLEN)) u_data (
        .clk      (clk),
        .rst_n    (rst_n),
        .d0_wr    (data0_wr),
        .d0_wdata (data0_wdata),
        .d1_wr    (data1_wr),
        .d1_wdata (data1_wdata),
        .cap_en   (cap_en),
        .cap_wide (acc_wide),
        .cap_val  (rd_val),
        .data0    (data0),
        .data1    (data1)
    );

    absacc_err u_err (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_en   (err_set),
        .set_code (err_code),
        .clr_wr   (err_clr_wr),
        .clr_mask (err_clr_mask),
        .cmderr   (cmderr)
    );

    // One response per posted command, a cycle later
    always_ff @(posedge clk) begin
        if (!rst_n)
            resp_q <= 1'b0;
        else
            resp_q <= cmd_wr;
    end
    assign resp_valid = resp_q;
    assign busy       = 1'b0;
    assign datacount  = 4'(DATA_REGS);

    // R1: every command gets a response next cycle
    resp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr |=> resp_valid);

    // R1: no response without a command
    resp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_wr |=> !resp_valid);

    // R2: at most one strobe toward the hart per cycle
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({gpr_rd, gpr_wr, fpr_rd, csr_rd, csr_wr}));

    // R7: a running hart is never touched
    run_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hart_halted |-> !(gpr_rd || gpr_wr || fpr_rd || csr_rd || csr_wr));

    // R6: trigger addresses never reach the CSR port
    trig_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_rd || csr_wr) |-> (csr_idx[11:4] != TRIG_BLOCK_HI));

    // R2: read data reaches the low data register on the next edge
    capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en |=> (data0 == $past(rd_val[31:0])));

    // R9: a command that arrives with an error pending raises no strobe
    sticky_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmderr != 3'd0) |-> !(gpr_rd || gpr_wr || fpr_rd || csr_rd || csr_wr));

endmodule

// File: tb/abs_access_engine_bench.sv
// Self-checking bench: behavioural reference model compared on every clock.
module abs_access_engine_bench;
    localparam int XLEN = 64;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            hart_halted = 1'b1;
    logic            cmd_wr = 1'b0;
    logic [31:0]     cmd_word = '0;
    logic            data0_wr = 1'b0;
    logic [31:0]     data0_wdata = '0;
    logic            data1_wr = 1'b0;
    logic [31:0]     data1_wdata = '0;
    logic            err_clr_wr = 1'b0;
    logic [2:0]      err_clr_mask = '0;
    logic [XLEN-1:0] gpr_rdata, fpr_rdata, csr_rdata;
    logic [4:0]      rf_idx;
    logic [11:0]     csr_idx;
    logic            gpr_rd, gpr_wr, fpr_rd, csr_rd, csr_wr;
    logic [XLEN-1:0] wr_data;
    logic [31:0]     data0, data1;
    logic [2:0]      cmderr;
    logic            busy;
    logic [3:0]      datacount;
    logic            resp_valid;

    // Hart-side storage
    logic [63:0] gpr_mem [0:31];
    logic [63:0] fpr_mem [0:31];
    logic [63:0] csr_mem [0:255];

    // Reference model state
    logic [31:0] exp_d0 = '0, exp_d1 = '0;
    logic [2:0]  exp_err = '0;
    logic        exp_resp = 1'b0;
    bit          chk_on = 1'b0;
    string       cur_req = "R1";
    int          checks = 0;
    int          failures = 0;
    int          cyc = 0;

    always #2 clk = ~clk;  // 250 MHz

    abs_access_engine #(.XLEN(XLEN)) u_abs_access_engine (
        .clk, .rst_n, .hart_halted, .cmd_wr, .cmd_word,
        .data0_wr, .data0_wdata, .data1_wr, .data1_wdata,
        .err_clr_wr, .err_clr_mask,
        .gpr_rdata, .fpr_rdata, .csr_rdata,
        .rf_idx, .csr_idx, .gpr_rd, .gpr_wr, .fpr_rd, .csr_rd, .csr_wr,
        .wr_data, .data0, .data1, .cmderr, .busy, .datacount, .resp_valid
    );

    assign gpr_rdata = gpr_mem[rf_idx];
    assign fpr_rdata = fpr_mem[rf_idx];
    assign csr_rdata = csr_mem[csr_idx[7:0]];

    // Hart obeys write strobes
    always @(posedge clk) begin
        if (gpr_wr) gpr_mem[rf_idx] <= wr_data;
        if (csr_wr) csr_mem[csr_idx[7:0]] <= wr_data;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    // Predicts outcome: kind 0 none,1 gpr rd,2 gpr wr,3 fpr rd,4 csr rd,5 csr wr
    function automatic void predict(input logic [31:0] w, input bit h,
                                    input logic [2:0] e, output int kind, output int err);
        int ctype = int'(w[31:24]);
        int size  = int'(w[22:20]);
        int regno = int'(w[15:0]);
        kind = 0;
        err  = 0;
        if (e != 0) return;
        if (!h) begin err = 4; return; end
        if (ctype != 0 || w[19] || w[18]) begin err = 2; return; end
        if (!w[17]) return;
        if (size != 2 && size != 3) begin err = 2; return; end
        if (regno < 'h1000) begin
            if (regno >= 'h7A0 && regno <= 'h7AF) err = 3;
            else kind = w[16] ? 5 : 4;
        end else if (regno >= 'h1000 && regno < 'h1020) begin
            kind = w[16] ? 2 : 1;
        end else if (regno >= 'h1020 && regno < 'h1040) begin
            if (w[16]) err = 2; else kind = 3;
        end else begin
            err = 2;
        end
    endfunction

    // Reference model, advanced on each edge from the driven inputs
    int          m_kind, m_err;
    logic [63:0] m_val;
    always @(posedge clk) begin
        if (!rst_n) begin
            exp_d0 <= '0; exp_d1 <= '0; exp_err <= '0; exp_resp <= 1'b0;
        end else begin
            predict(cmd_wr ? cmd_word : 32'h0000_0000, hart_halted, exp_err, m_kind, m_err);
            if (!cmd_wr) begin m_kind = 0; m_err = 0; end
            m_val = (m_kind == 1) ? gpr_mem[cmd_word[4:0]] :
                    (m_kind == 3) ? fpr_mem[cmd_word[4:0]] :
                    (m_kind == 4) ? csr_mem[cmd_word[7:0]] : 64'd0;
            exp_resp <= cmd_wr;
            if (m_kind == 1 || m_kind == 3 || m_kind == 4) begin
                exp_d0 <= m_val[31:0];
                if (cmd_word[22:20] == 3'd3) exp_d1 <= m_val[63:32];
                else if (data1_wr) exp_d1 <= data1_wdata;
            end else begin
                if (data0_wr) exp_d0 <= data0_wdata;
                if (data1_wr) exp_d1 <= data1_wdata;
            end
            if (m_err != 0) exp_err <= 3'(m_err);
            else if (err_clr_wr) exp_err <= exp_err & ~err_clr_mask;
        end
    end

    // Per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (chk_on) begin
            chk(data0 == exp_d0, cur_req, "data0", 64'(data0), 64'(exp_d0));
            chk(data1 == exp_d1, cur_req, "data1", 64'(data1), 64'(exp_d1));
            chk(cmderr == exp_err, cur_req, "cmderr", 64'(cmderr), 64'(exp_err));
            chk(resp_valid == exp_resp, "R1", "resp_valid", 64'(resp_valid), 64'(exp_resp));
            chk(busy == 1'b0, "R11", "busy", 64'(busy), 64'd0);
            chk(datacount == 4'd2, "R11", "datacount", 64'(datacount), 64'd2);
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 20000) begin
            failures++;
            checks++;
            $display("FAIL R1 watchdog actual=%0d expected<%0d", cyc, 20000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    function automatic logic [31:0] mk(input int size, input bit xfer, input bit wr,
                                       input logic [15:0] regno);
        return {8'd0, 1'b0, 3'(size), 1'b0, 1'b0, xfer, wr, regno};
    endfunction

    // Post one command; check strobes in the command cycle
    task automatic issue(input logic [31:0] w, input string req);
        int k, e, act, n;
        cur_req = req;
        @(negedge clk);
        cmd_wr = 1'b1;
        cmd_word = w;
        #1;
        predict(w, hart_halted, exp_err, k, e);
        act = gpr_rd ? 1 : gpr_wr ? 2 : fpr_rd ? 3 : csr_rd ? 4 : csr_wr ? 5 : 0;
        n = int'(gpr_rd) + int'(gpr_wr) + int'(fpr_rd) + int'(csr_rd) + int'(csr_wr);
        chk(act == k && n <= 1, req, "strobe", 64'(act), 64'(k));
        if (k >= 1 && k <= 3) chk(rf_idx == w[4:0], req, "rf_idx", 64'(rf_idx), 64'(w[4:0]));
        if (k >= 4) chk(csr_idx == w[11:0], req, "csr_idx", 64'(csr_idx), 64'(w[11:0]));
        if (k == 2 || k == 5)
            chk(wr_data == ((w[22:20] == 3'd3) ? {exp_d1, exp_d0} : {32'd0, exp_d0}),
                req, "wr_data", wr_data,
                (w[22:20] == 3'd3) ? {exp_d1, exp_d0} : {32'd0, exp_d0});
        @(negedge clk);
        cmd_wr = 1'b0;
    endtask

    task automatic dwrite(input logic [31:0] a, input logic [31:0] b, input string req);
        cur_req = req;
        @(negedge clk);
        data0_wr = 1'b1; data0_wdata = a;
        data1_wr = 1'b1; data1_wdata = b;
        @(negedge clk);
        data0_wr = 1'b0; data1_wr = 1'b0;
    endtask

    task automatic clear(input logic [2:0] m, input string req);
        cur_req = req;
        @(negedge clk);
        err_clr_wr = 1'b1; err_clr_mask = m;
        @(negedge clk);
        err_clr_wr = 1'b0;
    endtask

    task automatic expect_err(input logic [2:0] code, input string req);
        @(negedge clk);
        chk(cmderr == code, req, "error code", 64'(cmderr), 64'(code));
    endtask

    initial begin
        for (int i = 0; i < 32; i++) begin
            gpr_mem[i] = {32'h1000_0000 + 32'(i), 32'h2000_0000 + 32'(i * 7)};
            fpr_mem[i] = {32'h3F80_0000 + 32'(i), 32'h4000_0000 + 32'(i * 5)};
        end
        for (int i = 0; i < 256; i++) csr_mem[i] = 64'(i) * 64'h0101_0101;
        csr_mem[8'h41] = 64'h8000_0000_0000_1234;

        repeat (2) @(posedge clk);
        chk_on = 1'b1;
        @(negedge clk);
        chk(data0 == 0 && data1 == 0 && cmderr == 0 && resp_valid == 0,
            "R1", "reset state", {data0, data1}, 64'd0);
        rst_n = 1'b1;

        // R2: wide and narrow integer reads
        issue(mk(3, 1, 0, 16'h1005), "R2");
        issue(mk(2, 1, 0, 16'h1007), "R2");
        // R12 then R3: load data regs, wide write, read back
        dwrite(32'hCAFE_0001, 32'hBEEF_0002, "R12");
        issue(mk(3, 1, 1, 16'h1009), "R3");
        issue(mk(3, 1, 0, 16'h1009), "R3");
        // R3: narrow write zero-extends
        dwrite(32'h1357_9BDF, 32'h0F0F_0F0F, "R12");
        issue(mk(2, 1, 1, 16'h100A), "R3");
        issue(mk(3, 1, 0, 16'h100A), "R3");
        // R4: CSR read, write, read back
        issue(mk(3, 1, 0, 16'h0341), "R4");
        dwrite(32'h0000_00A5, 32'h7700_0000, "R12");
        issue(mk(3, 1, 1, 16'h0300), "R4");
        issue(mk(3, 1, 0, 16'h0300), "R4");
        // R5: floating-point read, then a forbidden write
        issue(mk(3, 1, 0, 16'h1023), "R5");
        issue(mk(3, 1, 1, 16'h1023), "R5");
        expect_err(3'd2, "R5");
        clear(3'b111, "R9");
        // R6: trigger register access
        issue(mk(3, 1, 0, 16'h07A2), "R6");
        expect_err(3'd3, "R6");
        // R9: command while error pending is ignored, partial clear
        issue(mk(3, 1, 0, 16'h1001), "R9");
        expect_err(3'd3, "R9");
        clear(3'b001, "R9");
        expect_err(3'd2, "R9");
        clear(3'b010, "R9");
        expect_err(3'd0, "R9");
        // R7: hart running
        @(negedge clk); hart_halted = 1'b0;
        issue(mk(3, 1, 0, 16'h1002), "R7");
        expect_err(3'd4, "R7");
        @(negedge clk); hart_halted = 1'b1;
        clear(3'b100, "R9");
        // R8: unsupported forms
        issue({8'd2, 24'h000000}, "R8");
        expect_err(3'd2, "R8");
        clear(3'b111, "R9");
        issue(mk(4, 1, 0, 16'h1003), "R8");
        expect_err(3'd2, "R8");
        clear(3'b111, "R9");
        issue(mk(1, 1, 0, 16'h1003), "R8");
        expect_err(3'd2, "R8");
        clear(3'b111, "R9");
        issue(mk(3, 1, 0, 16'h1003) | 32'h0004_0000, "R8");
        expect_err(3'd2, "R8");
        clear(3'b111, "R9");
        issue(mk(3, 1, 0, 16'h1003) | 32'h0008_0000, "R8");
        expect_err(3'd2, "R8");
        clear(3'b111, "R9");
        issue(mk(3, 1, 0, 16'hC000), "R8");
        expect_err(3'd2, "R8");
        clear(3'b111, "R9");
        // R10: no-transfer command
        issue(mk(5, 0, 0, 16'h0000), "R10");
        expect_err(3'd0, "R10");
        // R12: capture beats a same-cycle debugger write
        cur_req = "R12";
        @(negedge clk);
        cmd_wr = 1'b1; cmd_word = mk(3, 1, 0, 16'h1011);
        data0_wr = 1'b1; data0_wdata = 32'hDEAD_DEAD;
        @(negedge clk);
        cmd_wr = 1'b0; data0_wr = 1'b0;
        chk(data0 == gpr_mem[17][31:0], "R12", "precedence", 64'(data0), 64'(gpr_mem[17][31:0]));
        repeat (3) @(negedge clk);

        chk_on = 1'b0;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule